// File: doc/BRIEF.md
# Two-Wire Serial Command Receiver

This block accepts one command byte from an external microcontroller over two asynchronous wires: a data line and a clock line. The data line also frames the transfer. A falling edge on it stops whatever playback is running and opens a frame. The line must then stay low for a debounce period. When that period ends, the bit counter and the receive buffer are cleared. The sender then shifts eight bits in on the clock line, least significant bit first. When the data line is high after the eighth bit, the byte is committed.

A committed byte leaves the block as an interrupt vector with a one-cycle valid strobe, and a busy output goes high. Busy stays high while the routine that the vector selects is playing. It falls when the playing-status input drops, or when the next frame starts. Both wires pass through synchronizer flops before any logic uses them. Playback itself is outside the block; it appears only as the stop pulse and the playing-status input.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `halt_o`, `vec_valid_o`, `busy_o` and `vec_o` are all zero.
- R2: A high-to-low transition of `data_in` with no frame open produces exactly one `halt_o` pulse, one clock cycle long. In that same cycle `busy_o` is cleared.
- R3: `data_in` must stay low for `DEB_CYCLES` synchronized cycles. If it returns high before then, the frame is dropped and no vector is issued.
- R4: Rising edges on `sclk_in` that arrive before the debounce completes shift nothing in. The bit counter and the buffer are cleared when the debounce completes.
- R5: Each rising edge of `sclk_in` after the debounce samples `data_in` as the next bit. The first bit sampled becomes bit 0 of the byte and the eighth becomes bit 7.
- R6: Once eight bits are held and `data_in` is high, `vec_valid_o` pulses for exactly one cycle and `vec_o` carries the byte. `vec_o` keeps that value until the next commit.
- R7: If bit 7 is 1, `busy_o` rises shortly after the eighth clock rising edge, with no further change on either wire. If bit 7 is 0, `busy_o` stays low until `data_in` returns high.
- R8: Clock rising edges after the eighth bit change neither the byte nor the commit.
- R9: `busy_o` rises together with `vec_valid_o`. It stays high until `playing_i` falls from 1 to 0 or a new frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 1 | Serial data and frame line, asynchronous, idles high |
| sclk_in | input | 1 | Serial clock, asynchronous |
| playing_i | input | 1 | High while the requested routine is playing |
| halt_o | output | 1 | One-cycle pulse that stops current playback |
| vec_valid_o | output | 1 | One-cycle strobe for a committed byte |
| vec_o | output | NBITS | Received byte, used as the interrupt vector |
| busy_o | output | 1 | High from commit until playback ends |

## Verification
Every one of the 256 byte values is sent in turn.

- **Bit order:** a receiver with reversed bit order, or with the first sample dropped, gives the wrong vector for almost every byte.
- **Busy timing against bit 7:** the bench samples `busy_o` while the eighth clock pulse is still high. A design that waits for a data transition would leave busy low for bytes with bit 7 set. A design that commits on the eighth edge alone would raise busy early for bytes with bit 7 clear.
- **Spurious clock pulses:** some pulses are sent during the debounce window and one extra pulse after the eighth bit. Shifting on either of these would corrupt the vector.
- **Short low glitch:** a low pulse on `data_in` shorter than the debounce time must give a halt pulse but no vector.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEB  = 2'd1,
        ST_RECV = 2'd2
    } scr_state_e;

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int         WIDTH   = 2,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/scr_edge.sv
module scr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic data_s,
    input  logic sclk_s,
    input  logic play_s,
    output logic data_fall,
    output logic sclk_rise,
    output logic play_fall
);

    typedef struct packed {
        logic data;
        logic sclk;
        logic play;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.data = data_s;
        prev_d.sclk = sclk_s;
        prev_d.play = play_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q.data <= 1'b1;
            prev_q.sclk <= 1'b0;
            prev_q.play <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign data_fall = prev_q.data & ~data_s;
    assign sclk_rise = ~prev_q.sclk & sclk_s;
    assign play_fall = prev_q.play & ~play_s;

endmodule

// File: rtl/scr_frame.sv
module scr_frame
    import scr_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int DEB_CYCLES = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_lvl,
    input  logic             data_fall,
    input  logic             sclk_rise,
    input  logic             play_fall,
    output logic             halt_o,
    output logic             vec_valid_o,
    output logic [NBITS-1:0] vec_o,
    output logic             busy_o
);

    localparam int DW = $clog2(DEB_CYCLES + 1);
    localparam int BW = $clog2(NBITS + 1);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYCLES - 1);
    localparam logic [BW-1:0] BIT_FULL = BW'(NBITS);

    typedef struct packed {
        scr_state_e       st;
        logic [DW-1:0]    deb;
        logic [BW-1:0]    bits;
        logic [NBITS-1:0] shreg;
        logic [NBITS-1:0] vec;
        logic             valid;
        logic             halt;
        logic             busy;
    } frame_t;

    frame_t fr_d, fr_q;

    always_comb begin
        fr_d       = fr_q;
        fr_d.valid = 1'b0;
        fr_d.halt  = 1'b0;
        if (play_fall) begin
            fr_d.busy = 1'b0;
        end
        unique case (fr_q.st)
            ST_IDLE: begin
                if (data_fall) begin
                    fr_d.halt = 1'b1;
                    fr_d.busy = 1'b0;
                    fr_d.deb  = '0;
                    fr_d.st   = ST_DEB;
                end
            end
            ST_DEB: begin
                if (data_lvl) begin
                    fr_d.st = ST_IDLE;
                end else if (fr_q.deb == DEB_LAST) begin
                    fr_d.bits  = '0;
                    fr_d.shreg = '0;
                    fr_d.st    = ST_RECV;
                end else begin
                    fr_d.deb = fr_q.deb + 1'b1;
                end
            end
            ST_RECV: begin
                if (fr_q.bits == BIT_FULL) begin
                    if (data_lvl) begin
                        fr_d.vec   = fr_q.shreg;
                        fr_d.valid = 1'b1;
                        fr_d.busy  = 1'b1;
                        fr_d.st    = ST_IDLE;
                    end
                end else if (sclk_rise) begin
                    fr_d.shreg = {data_lvl, fr_q.shreg[NBITS-1:1]};
                    fr_d.bits  = fr_q.bits + 1'b1;
                end
            end
            default: fr_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q.st    <= ST_IDLE;
            fr_q.deb   <= '0;
            fr_q.bits  <= '0;
            fr_q.shreg <= '0;
            fr_q.vec   <= '0;
            fr_q.valid <= 1'b0;
            fr_q.halt  <= 1'b0;
            fr_q.busy  <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign halt_o      = fr_q.halt;
    assign vec_valid_o = fr_q.valid;
    assign vec_o       = fr_q.vec;
    assign busy_o      = fr_q.busy;

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
    parameter int NBITS       = 8,
    parameter int DEB_CYCLES  = 8000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_in,
    input  logic             sclk_in,
    input  logic             playing_i,
    output logic             halt_o,
    output logic             vec_valid_o,
    output logic [NBITS-1:0] vec_o,
    output logic             busy_o
);

    logic [1:0] pins_s;
    logic       data_fall, sclk_rise, play_fall;

    scr_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_in, data_in}),
        .sync_o  (pins_s)
    );

    scr_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_s    (pins_s[0]),
        .sclk_s    (pins_s[1]),
        .play_s    (playing_i),
        .data_fall (data_fall),
        .sclk_rise (sclk_rise),
        .play_fall (play_fall)
    );

    scr_frame #(
        .NBITS      (NBITS),
        .DEB_CYCLES (DEB_CYCLES)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_lvl    (pins_s[0]),
        .data_fall   (data_fall),
        .sclk_rise   (sclk_rise),
        .play_fall   (play_fall),
        .halt_o      (halt_o),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o),
        .busy_o      (busy_o)
    );

endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic playing_i,
    input logic halt_o,
    input logic vec_valid_o,
    input logic busy_o
);

    // R2: the stop pulse lasts a single cycle
    assert_halt_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> !halt_o);

    // R2: a new frame drops busy
    assert_halt_clears_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !busy_o);

    // R6: the commit strobe lasts a single cycle
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    // R9: busy is high whenever a byte is committed
    assert_valid_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> busy_o);

    // R9: busy only rises together with a commit
    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> vec_valid_o);

    // R6: stop and commit never coincide
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_o && vec_valid_o));

endmodule

bind serial_cmd_rx serial_cmd_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .playing_i   (playing_i),
    .halt_o      (halt_o),
    .vec_valid_o (vec_valid_o),
    .busy_o      (busy_o)
);

// File: tb/serial_cmd_rx_tb.sv
`timescale 1ns/1ps
module serial_cmd_rx_tb;

    localparam int NB  = 8;
    localparam int DEB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          data_in = 1'b1;
    logic          sclk_in = 1'b0;
    logic          playing_i = 1'b0;
    logic          halt_o, vec_valid_o, busy_o;
    logic [NB-1:0] vec_o;

    int tests = 0;
    int fails = 0;
    int vcount = 0;
    int hcount = 0;
    logic [NB-1:0] vlast = '0;

    always #4 clk = ~clk;

    serial_cmd_rx #(.NBITS(NB), .DEB_CYCLES(DEB), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_in     (data_in),
        .sclk_in     (sclk_in),
        .playing_i   (playing_i),
        .halt_o      (halt_o),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o),
        .busy_o      (busy_o)
    );

    always @(negedge clk) begin
        if (vec_valid_o) begin
            vcount <= vcount + 1;
            vlast  <= vec_o;
        end
        if (halt_o) hcount <= hcount + 1;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_counts();
        @(negedge clk);
        vcount = 0;
        hcount = 0;
    endtask

    // sends one byte; pre adds clock pulses during debounce, post adds one after bit 7
    task automatic send_byte(input logic [NB-1:0] b, input int pre, input bit post);
        data_in = 1'b0;
        cyc(2);
        for (int k = 0; k < pre; k++) begin
            sclk_in = 1'b1; cyc(2);
            sclk_in = 1'b0; cyc(1);
        end
        cyc(DEB + 8 - 3 * pre);
        for (int i = 0; i < NB; i++) begin
            data_in = b[i];
            cyc(3);
            sclk_in = 1'b1;
            cyc(6);
            if (i == NB - 1) begin
                check(busy_o == b[NB-1], "R7 busy at last clock", busy_o, b[NB-1]);
            end
            sclk_in = 1'b0;
            cyc(3);
        end
        if (post && !b[NB-1]) begin
            data_in = 1'b0; cyc(3);
            sclk_in = 1'b1; cyc(4);
            sclk_in = 1'b0; cyc(3);
            check(busy_o == 1'b0, "R8 no commit on extra clock", busy_o, 0);
        end
        data_in = 1'b1;
        cyc(8);
    endtask

    initial begin
        cyc(150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        cyc(4);
        check(halt_o == 0 && vec_valid_o == 0 && busy_o == 0, "R1 control outputs", int'({halt_o, vec_valid_o, busy_o}), 0);
        check(vec_o == '0, "R1 vector", vec_o, 0);
        rst_n = 1'b1;
        cyc(4);

        // R5 R6 R7 R9: sweep every byte value
        for (int v = 0; v < (1 << NB); v++) begin
            clr_counts();
            send_byte(NB'(v), 0, 1'b0);
            check(vcount == 1, "R6 one strobe", vcount, 1);
            check(vlast == NB'(v), "R5 byte value", vlast, v);
            check(vec_o == NB'(v), "R6 vector held", vec_o, v);
            check(hcount == 1, "R2 one halt pulse", hcount, 1);
            check(busy_o == 1'b1, "R9 busy after commit", busy_o, 1);
            playing_i = 1'b1; cyc(4);
            check(busy_o == 1'b1, "R9 busy held while playing", busy_o, 1);
            playing_i = 1'b0; cyc(3);
            check(busy_o == 1'b0, "R9 busy drops at end of play", busy_o, 0);
        end

        // R3: short low glitch gives halt but no vector
        clr_counts();
        data_in = 1'b0; cyc(DEB / 2);
        data_in = 1'b1; cyc(DEB + 8);
        check(vcount == 0, "R3 glitch yields no vector", vcount, 0);
        check(hcount == 1, "R2 glitch still halts", hcount, 1);
        check(vec_o == NB'(255), "R3 vector unchanged", vec_o, 255);

        // R4: clock pulses during debounce are ignored
        clr_counts();
        send_byte(8'h5A, 4, 1'b0);
        check(vcount == 1 && vlast == 8'h5A, "R4 early clocks ignored", vlast, 8'h5A);

        // R8: an extra clock after bit 7 (bit 7 clear) changes nothing
        clr_counts();
        send_byte(8'h22, 0, 1'b1);
        check(vcount == 1 && vlast == 8'h22, "R8 extra clock ignored", vlast, 8'h22);

        // R9: a new frame clears busy without playback ending
        check(busy_o == 1'b1, "R9 busy before new frame", busy_o, 1);
        data_in = 1'b0; cyc(6);
        check(busy_o == 1'b0, "R9 new frame clears busy", busy_o, 0);
        data_in = 1'b1; cyc(DEB + 8);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule